// File: doc/BRIEF.md
# Byte-Lane Peripheral Register Bank

This block is a small bank of word-wide registers attached to a simple single-cycle peripheral bus. On every clock cycle the bus master can hold an active-high enable and present a word address, a write data word and one write strobe per byte. A cycle with enable high and no strobe set is a read. A cycle with at least one strobe set is a write.

Read data is decoded combinationally from the address, so it is valid in the same cycle as the access. A write is committed on the rising clock edge that closes the access cycle. Each byte lane is written on its own, and a lane whose strobe is clear keeps its old contents.

The bank only answers inside a window of word addresses, from a base address up to the base plus the register count minus one. The address bus is always 14 bits wide, which covers a 32 KB peripheral space, because the CPU's byte address is twice the word address. When no valid access is in progress, the read data output is held at all zeros. This lets several such slaves share an OR-combined read bus.

Top module: `periph_regbank`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. A read at any in-range address after reset returns 16'h0000.
- R2: While the enable input is low, the read data output is 16'h0000, whatever the address and write strobes are.
- R3: During a read (enable high, strobes 2'b00) at an in-range address, the read data output carries that register's value in the same cycle. It follows an address change within the cycle without waiting for a clock edge.
- R4: A write becomes visible on the rising edge after the access cycle. During the write cycle itself the output shows the contents held before that edge.
- R5: Strobe value 2'b01 (bit 0) writes only bits 7:0 of the addressed register. Bits 15:8 keep their value.
- R6: Strobe value 2'b10 (bit 1) writes only bits 15:8 of the addressed register. Bits 7:0 keep their value.
- R7: Strobe value 2'b11 writes the full 16-bit word.
- R8: A read access changes no register, whatever value is on the write data input.
- R9: At an address outside the window, an access writes nothing and the output stays 16'h0000.
- R10: The window includes the base address and base plus count minus one. It excludes base minus one and base plus count.
- R11: A write presented while enable is low has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access valid in this cycle (active high) |
| bus_addr | input | 14 | Word address of the access |
| bus_wdata | input | 16 | Write data word |
| bus_wstrb | input | 2 | Byte write strobes: bit 0 low byte, bit 1 high byte |
| bus_rdata | output | 16 | Read data; zero unless a valid in-range access is present |

## Verification
The bench builds the bank with a base word address of 14'h123 and five registers. The base is not aligned to any power of two, so the window decode has to work by subtraction and comparison rather than by matching high address bits. The count is not a power of two, so the index width leaves unused index codes. With these values, addresses just past the top of the window are reached and can expose aliasing from index truncation. The address just below the base is also reached, so a wrap-around from a negative offset would be caught. Both window edges are exercised by a write followed by a readback.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  function automatic acc_kind_t classify(input logic en, input logic any_strobe,
                                         input logic in_window);
    if (!en || !in_window) return ACC_IDLE;
    if (any_strobe)        return ACC_WRITE;
    return ACC_READ;
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int              ADDR_W   = 14,
  parameter logic [ADDR_W-1:0] BASE   = 14'h0040,
  parameter int              NUM_REGS = 8,
  parameter int              IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W:0] BASE_X = {1'b0, BASE};
  localparam logic [ADDR_W:0] COUNT  = (ADDR_W+1)'(NUM_REGS);

  logic [ADDR_W:0] offset;
  logic            above_base;

  always_comb begin
    offset     = {1'b0, addr} - BASE_X;
    above_base = ({1'b0, addr} >= BASE_X);
    in_window  = above_base && (offset < COUNT);
    idx        = offset[IDX_W-1:0];
  end

endmodule

// File: rtl/regbank_lane.sv
module regbank_lane #(
  parameter int NUM_REGS = 8,
  parameter int LANE_W   = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wr_byte,
  output logic [LANE_W-1:0] rd_byte
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  logic [LANE_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= wr_byte;
    end
  end

  always_comb begin
    if ({1'b0, idx} < LIMIT) rd_byte = mem[idx];
    else                     rd_byte = '0;
  end

endmodule

// File: rtl/periph_regbank.sv
module periph_regbank #(
  parameter int                ADDR_W    = 14,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_WORD = 14'h0040,
  parameter int                NUM_REGS  = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_en,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  input  logic [DATA_W/regbank_pkg::LANE_W-1:0] bus_wstrb,
  output logic [DATA_W-1:0]                bus_rdata
);
  import regbank_pkg::*;

  localparam int LANES = DATA_W / LANE_W;
  localparam int IDX_W = idx_width(NUM_REGS);

  logic             in_window;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] word;
  acc_kind_t        kind;

  regbank_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE_WORD), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) u_decode (
    .addr(bus_addr), .in_window(in_window), .idx(idx)
  );

  always_comb kind = classify(bus_en, |bus_wstrb, in_window);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_we;
    always_comb lane_we = (kind == ACC_WRITE) && bus_wstrb[l];

    regbank_lane #(
      .NUM_REGS(NUM_REGS), .LANE_W(LANE_W), .IDX_W(IDX_W)
    ) u_lane (
      .clk(clk),
      .rst(rst),
      .wr_en(lane_we),
      .idx(idx),
      .wr_byte(bus_wdata[l*LANE_W +: LANE_W]),
      .rd_byte(word[l*LANE_W +: LANE_W])
    );
  end

  always_comb bus_rdata = (kind == ACC_IDLE) ? '0 : word;

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int                ADDR_W    = 14,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_WORD = 14'h0040,
  parameter int                NUM_REGS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [1:0]        bus_wstrb,
  input logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W:0] LO = {1'b0, BASE_WORD};
  localparam logic [ADDR_W:0] HI = {1'b0, BASE_WORD} + (ADDR_W+1)'(NUM_REGS);

  logic hit;
  always_comb hit = ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI);

  logic rd_same;
  always_comb rd_same = bus_en && (bus_wstrb == 2'b00) && hit;

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_en |-> bus_rdata == '0);

  a_r9_outside_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !hit) |-> bus_rdata == '0);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd_same) |-> bus_rdata == '0);

  a_r7_word_lands: assert property (@(posedge clk) disable iff (rst)
    (rd_same && !$past(rst) && $past(bus_en && hit && bus_wstrb == 2'b11)
     && bus_addr == $past(bus_addr)) |-> bus_rdata == $past(bus_wdata));

  a_r5_low_lane: assert property (@(posedge clk) disable iff (rst)
    (rd_same && !$past(rst) && $past(bus_en && hit && bus_wstrb == 2'b01)
     && bus_addr == $past(bus_addr))
    |-> (bus_rdata[7:0] == $past(bus_wdata[7:0])
         && bus_rdata[15:8] == $past(bus_rdata[15:8])));

  a_r6_high_lane: assert property (@(posedge clk) disable iff (rst)
    (rd_same && !$past(rst) && $past(bus_en && hit && bus_wstrb == 2'b10)
     && bus_addr == $past(bus_addr))
    |-> (bus_rdata[15:8] == $past(bus_wdata[15:8])
         && bus_rdata[7:0] == $past(bus_rdata[7:0])));

  a_r8_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (rd_same && !$past(rst) && $past(rd_same) && bus_addr == $past(bus_addr))
    |-> bus_rdata == $past(bus_rdata));

endmodule

bind periph_regbank regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_WORD(BASE_WORD), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata)
);

// File: tb/sim_periph_regbank.sv
module sim_periph_regbank;

  localparam logic [13:0] BASE = 14'h0123;
  localparam int          NREG = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_wstrb = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  periph_regbank #(
    .ADDR_W(14), .DATA_W(16), .BASE_WORD(BASE), .NUM_REGS(NREG)
  ) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        en;
    logic [13:0] addr;
    logic [1:0]  we;
    logic [15:0] din;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Applied back to back, one per cycle, starting from a cleared bank.
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 14'h123, 2'b11, 16'hA1B2, 16'h0000, 8'd4},  // R4 old value during write
    '{1'b1, 14'h123, 2'b00, 16'h0000, 16'hA1B2, 8'd7},  // R7 full word
    '{1'b1, 14'h124, 2'b01, 16'h5566, 16'h0000, 8'd5},  // R5 low lane write
    '{1'b1, 14'h124, 2'b00, 16'h0000, 16'h0066, 8'd5},  // R5
    '{1'b1, 14'h124, 2'b10, 16'h7788, 16'h0066, 8'd6},  // R6 high lane write
    '{1'b1, 14'h124, 2'b00, 16'h0000, 16'h7766, 8'd6},  // R6
    '{1'b0, 14'h124, 2'b00, 16'h0000, 16'h0000, 8'd2},  // R2 idle output
    '{1'b1, 14'h127, 2'b11, 16'hFFFF, 16'h0000, 8'd10}, // R10 top edge
    '{1'b1, 14'h127, 2'b00, 16'h0000, 16'hFFFF, 8'd10}, // R10
    '{1'b1, 14'h128, 2'b11, 16'h1234, 16'h0000, 8'd9},  // R9 beyond top
    '{1'b1, 14'h128, 2'b00, 16'h0000, 16'h0000, 8'd9},  // R9
    '{1'b1, 14'h122, 2'b11, 16'h4321, 16'h0000, 8'd9},  // R9 below base
    '{1'b1, 14'h122, 2'b00, 16'h0000, 16'h0000, 8'd10}, // R10 base minus one
    '{1'b0, 14'h125, 2'b11, 16'h9999, 16'h0000, 8'd11}, // R11 write with enable low
    '{1'b1, 14'h125, 2'b00, 16'h0000, 16'h0000, 8'd11}, // R11
    '{1'b1, 14'h123, 2'b00, 16'hDEAD, 16'hA1B2, 8'd8},  // R8 read ignores data
    '{1'b1, 14'h123, 2'b00, 16'h0000, 16'hA1B2, 8'd8},  // R8
    '{1'b1, 14'h126, 2'b00, 16'h0000, 16'h0000, 8'd9},  // R9 no alias from 128
    '{1'b1, 14'h127, 2'b00, 16'h0000, 16'hFFFF, 8'd3}   // R3 read
  };

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, bus_rdata, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [13:0] a, input logic [1:0] we,
                       input logic [15:0] d);
    @(negedge clk);
    bus_en = en; bus_addr = a; bus_wstrb = we; bus_wdata = d;
    #2;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R2 idle during reset", 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].en, VECS[i].addr, VECS[i].we, VECS[i].din);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R3: address change inside one cycle, no clock edge between
    drive(1'b1, 14'h124, 2'b00, 16'h0000);
    check("R3 read 124", 16'h7766);
    #1 bus_addr = 14'h123;
    #0.5 check("R3 same-cycle address change", 16'hA1B2);

    // R1: reset clears populated registers
    @(negedge clk);
    bus_en = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 14'h123, 2'b00, 16'h0000);
    check("R1 cleared 123", 16'h0000);
    drive(1'b1, 14'h124, 2'b00, 16'h0000);
    check("R1 cleared 124", 16'h0000);
    drive(1'b1, 14'h127, 2'b00, 16'h0000);
    check("R1 cleared 127", 16'h0000);

    // R10: base address write after reset, then readback
    drive(1'b1, 14'h123, 2'b11, 16'h0F0F);
    drive(1'b1, 14'h123, 2'b00, 16'h0000);
    check("R10 base readback", 16'h0F0F);

    drive(1'b0, 14'h000, 2'b00, 16'h0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule